// File: doc/BRIEF.md
# PHY Power-Up Reset Sequencer

This block brings a serial-link PHY and its controller out of reset in a fixed order. It needs no software timing. A start pulse releases the PHY power-down. After a short settle time the block enables the reference clock. It then waits for the clocks to stabilise and, if the board has a reset pin, holds that pin active for a long pulse. Finally it releases the PHY reset and samples a PLL-locked flag on a regular grid, up to a bounded number of tries.

All delays are counted in cycles of the block clock. They are given as microsecond and millisecond parameters, scaled by a cycles-per-microsecond parameter. The sequence always ends in the done state. A lock that never arrives also sets a sticky timeout flag, so that the next stage can still go on and decide what to do. A shutdown input returns every output to its reset level at any time, so the link comes down cleanly.

Top module: `phy_pwrup_seq`

## Requirements
- R1: While reset is held, and until the first start, the outputs are: `phy_pd_o`=1, `refclk_en_o`=0, `phy_rst_o`=1, `done_o`=0, `lock_to_o`=0, and `board_rst_o` at its inactive level. The inactive level is `~pin_act_high_i`.
- R2: A start accepted in the idle state clears `phy_pd_o` in the next cycle. `refclk_en_o` rises exactly SETTLE_US*CLK_PER_US cycles after `phy_pd_o` falls.
- R3: With `pin_present_i`=1, `board_rst_o` goes to its active level exactly STAB_US*CLK_PER_US cycles after `refclk_en_o` rises. It holds that level for exactly PULSE_MS*1000*CLK_PER_US cycles. It returns to the inactive level in the same cycle that `phy_rst_o` falls.
- R4: The active level of `board_rst_o` equals `pin_act_high_i`: 1 when the strap is 1 and 0 when it is 0.
- R5: With `pin_present_i`=0, the pulse phase is skipped. `phy_rst_o` falls exactly STAB_US*CLK_PER_US cycles after `refclk_en_o` rises, and `board_rst_o` never leaves its inactive level.
- R6: After `phy_rst_o` falls, `pll_locked_i` is sampled at the first clock edge and then every POLL_GAP_US*CLK_PER_US cycles. `done_o` rises in the cycle after a sample that sees the flag set. A level of the flag that lies between sample points has no effect.
- R7: If none of POLL_MAX samples sees the lock, `done_o` rises (POLL_MAX-1)*POLL_GAP_US*CLK_PER_US+1 cycles after `phy_rst_o` falls, and `lock_to_o` rises with it.
- R8: `done_o` and `lock_to_o` hold until the next start. A start in the done state clears both in the next cycle and restarts the sequence from power-up.
- R9: A start while a sequence is running is ignored. The running sequence keeps its timing.
- R10: `shutdown_i` has priority over start. In the next cycle it returns `phy_pd_o`, `refclk_en_o`, `phy_rst_o`, `board_rst_o` and `done_o` to their R1 levels, and it leaves `lock_to_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all delays count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a power-up sequence |
| shutdown_i | input | 1 | Return to the all-reset state |
| pll_locked_i | input | 1 | PHY PLL locked flag |
| pin_act_high_i | input | 1 | Strap: board reset pin is active high |
| pin_present_i | input | 1 | Strap: board reset pin exists |
| phy_pd_o | output | 1 | PHY power-down, 1 = powered down |
| refclk_en_o | output | 1 | Reference clock enable |
| board_rst_o | output | 1 | Board reset pin level |
| phy_rst_o | output | 1 | PHY reset, 1 = held in reset |
| done_o | output | 1 | Sequence finished |
| lock_to_o | output | 1 | Sticky PLL lock timeout |

## Verification
The bench measures each interval in cycles from one output edge to the next. An off-by-one in the countdown would shift an edge by one cycle, and the bench would see it. The lock poll gets a flag pulse that lies wholly between two sample points, followed by a flag that rises just before a sample point. A poller that looks at the flag every cycle would finish early, and one with a wrong grid would finish late. The bench also runs a full timeout, checks the exact cycle of done and that the timeout flag stays set, tries a restart that must clear it, sends a mid-sequence start that must not disturb timing, and sends a shutdown together with a start. A design that let start win over shutdown, or that cleared the timeout flag on shutdown, would fail these checks.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWRUP,
        ST_REFON,
        ST_PULSE,
        ST_POLL,
        ST_DONE
    } pwrseq_state_e;

    typedef struct packed {
        pwrseq_state_e st;
        logic          err;
    } pwrseq_regs_t;
endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pwrseq_tries.sv
module pwrseq_tries #(
    parameter int MAX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CW = $clog2(MAX + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (inc_i)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == CW'(MAX - 1));
endmodule

// File: rtl/phy_pwrup_seq.sv
module phy_pwrup_seq #(
    parameter int CLK_PER_US  = 125,
    parameter int SETTLE_US   = 10,
    parameter int STAB_US     = 200,
    parameter int PULSE_MS    = 100,
    parameter int POLL_GAP_US = 50,
    parameter int POLL_MAX    = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic shutdown_i,
    input  logic pll_locked_i,
    input  logic pin_act_high_i,
    input  logic pin_present_i,
    output logic phy_pd_o,
    output logic refclk_en_o,
    output logic board_rst_o,
    output logic phy_rst_o,
    output logic done_o,
    output logic lock_to_o
);
    import pwrseq_pkg::*;

    localparam int US_PER_MS = 1000;
    localparam int T_SETTLE  = (SETTLE_US * CLK_PER_US < 1) ? 1 : SETTLE_US * CLK_PER_US;
    localparam int T_STAB    = (STAB_US * CLK_PER_US < 1) ? 1 : STAB_US * CLK_PER_US;
    localparam int T_PULSE   = (PULSE_MS * US_PER_MS * CLK_PER_US < 1) ? 1
                             : PULSE_MS * US_PER_MS * CLK_PER_US;
    localparam int T_GAP     = (POLL_GAP_US * CLK_PER_US < 1) ? 1 : POLL_GAP_US * CLK_PER_US;
    localparam int T_MAX_A   = (T_SETTLE > T_STAB) ? T_SETTLE : T_STAB;
    localparam int T_MAX_B   = (T_PULSE > T_GAP) ? T_PULSE : T_GAP;
    localparam int T_MAX     = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
    localparam int TW        = $clog2(T_MAX + 1);

    pwrseq_regs_t r_d, r_q;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          try_clr, try_inc, try_last;
    logic          pulse_act;

    pwrseq_timer #(.W(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    pwrseq_tries #(.MAX(POLL_MAX)) u_tries (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (try_clr),
        .inc_i  (try_inc),
        .last_o (try_last)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        try_clr  = 1'b0;
        try_inc  = 1'b0;

        case (r_q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    r_d.st   = ST_PWRUP;
                    r_d.err  = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(T_SETTLE - 1);
                end
            end
            ST_PWRUP: begin
                if (tmr_zero) begin
                    r_d.st   = ST_REFON;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(T_STAB - 1);
                end
            end
            ST_REFON: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (pin_present_i) begin
                        r_d.st  = ST_PULSE;
                        tmr_val = TW'(T_PULSE - 1);
                    end else begin
                        r_d.st  = ST_POLL;
                        try_clr = 1'b1;
                    end
                end
            end
            ST_PULSE: begin
                if (tmr_zero) begin
                    r_d.st   = ST_POLL;
                    tmr_load = 1'b1;
                    try_clr  = 1'b1;
                end
            end
            ST_POLL: begin
                if (tmr_zero) begin
                    if (pll_locked_i) begin
                        r_d.st = ST_DONE;
                    end else if (try_last) begin
                        r_d.st  = ST_DONE;
                        r_d.err = 1'b1;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_val  = TW'(T_GAP - 1);
                        try_inc  = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (shutdown_i) begin
            r_d.st   = ST_IDLE;
            r_d.err  = r_q.err;
            tmr_load = 1'b1;
            tmr_val  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, err: 1'b0};
        else        r_q <= r_d;
    end

    assign pulse_act   = (r_q.st == ST_PULSE);
    assign phy_pd_o    = (r_q.st == ST_IDLE);
    assign refclk_en_o = (r_q.st != ST_IDLE) && (r_q.st != ST_PWRUP);
    assign board_rst_o = pulse_act ? pin_act_high_i : ~pin_act_high_i;
    assign phy_rst_o   = (r_q.st != ST_POLL) && (r_q.st != ST_DONE);
    assign done_o      = (r_q.st == ST_DONE);
    assign lock_to_o   = r_q.err;
endmodule

// File: rtl/pwrseq_checks.sv
module pwrseq_checks (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic shutdown_i,
    input logic phy_pd_o,
    input logic refclk_en_o,
    input logic phy_rst_o,
    input logic done_o,
    input logic lock_to_o
);
    AST_REFCLK_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        refclk_en_o |-> !phy_pd_o);                                         // R2
    AST_RELEASE_NEEDS_REFCLK: assert property (@(posedge clk) disable iff (!rst_n)
        !phy_rst_o |-> refclk_en_o);                                        // R3
    AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !phy_rst_o);                                             // R6
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i && !shutdown_i) |=> done_o);                    // R8
    AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_to_o && !start_i) |=> lock_to_o);                             // R8
    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !shutdown_i && (phy_pd_o || done_o))
        |=> (!lock_to_o && !phy_pd_o && !done_o));                          // R8
    AST_SHUTDOWN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_i |=> (phy_pd_o && !refclk_en_o && phy_rst_o && !done_o)); // R10
endmodule

bind phy_pwrup_seq pwrseq_checks u_pwrseq_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .shutdown_i  (shutdown_i),
    .phy_pd_o    (phy_pd_o),
    .refclk_en_o (refclk_en_o),
    .phy_rst_o   (phy_rst_o),
    .done_o      (done_o),
    .lock_to_o   (lock_to_o)
);

// File: tb/test_phy_pwrup_seq.sv
`timescale 1ns/1ps
module test_phy_pwrup_seq;
    localparam int CPU   = 2;
    localparam int S_US  = 3;
    localparam int ST_US = 5;
    localparam int P_MS  = 1;
    localparam int G_US  = 4;
    localparam int PMAX  = 6;
    localparam int T_S   = S_US * CPU;
    localparam int T_ST  = ST_US * CPU;
    localparam int T_P   = P_MS * 1000 * CPU;
    localparam int T_G   = G_US * CPU;
    localparam int LIMIT = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, shutdown_i = 1'b0, pll_locked_i = 1'b0;
    logic pin_act_high_i = 1'b1, pin_present_i = 1'b1;
    logic phy_pd_o, refclk_en_o, board_rst_o, phy_rst_o, done_o, lock_to_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    phy_pwrup_seq #(
        .CLK_PER_US(CPU), .SETTLE_US(S_US), .STAB_US(ST_US),
        .PULSE_MS(P_MS), .POLL_GAP_US(G_US), .POLL_MAX(PMAX)
    ) i_phy_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .shutdown_i(shutdown_i),
        .pll_locked_i(pll_locked_i), .pin_act_high_i(pin_act_high_i),
        .pin_present_i(pin_present_i), .phy_pd_o(phy_pd_o),
        .refclk_en_o(refclk_en_o), .board_rst_o(board_rst_o),
        .phy_rst_o(phy_rst_o), .done_o(done_o), .lock_to_o(lock_to_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic sel(input int which);
        case (which)
            0: sel = phy_pd_o;
            1: sel = refclk_en_o;
            2: sel = board_rst_o;
            3: sel = phy_rst_o;
            default: sel = done_o;
        endcase
    endfunction

    // count negedges until the selected output reaches val
    task automatic wait_for(input int which, input logic val, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sel(which) !== val && n < LIMIT);
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic check_reset_levels(input string req);
        chk({req, " pd"}, phy_pd_o, 1);
        chk({req, " refclk"}, refclk_en_o, 0);
        chk({req, " phyrst"}, phy_rst_o, 1);
        chk({req, " board"}, board_rst_o, !pin_act_high_i);
        chk({req, " done"}, done_o, 0);
    endtask

    // R1
    task automatic t_reset();
        check_reset_levels("R1");
        chk("R1 err", lock_to_o, 0);
    endtask

    // R2 R3 R4 R6: full sequence with a pin, lock already present
    task automatic t_full(input logic hi);
        int n;
        pin_act_high_i = hi;
        pin_present_i  = 1'b1;
        pll_locked_i   = 1'b1;
        @(negedge clk);
        chk("R4 idle level", board_rst_o, !hi);
        pulse_start();
        chk("R2 pd falls", phy_pd_o, 0);
        wait_for(1, 1'b1, n);
        chk("R2 settle", n, T_S);
        wait_for(2, hi, n);
        chk("R3 stab", n, T_ST);
        chk("R4 active level", board_rst_o, hi);
        wait_for(3, 1'b0, n);
        chk("R3 pulse", n, T_P);
        chk("R3 pin released", board_rst_o, !hi);
        wait_for(4, 1'b1, n);
        chk("R6 done one cycle", n, 1);
        chk("R6 no err", lock_to_o, 0);
    endtask

    // R5 R9 R6: no pin, mid-run start, flag between samples
    task automatic t_nopin_grid();
        int n, act;
        pin_present_i = 1'b0;
        pin_act_high_i = 1'b1;
        pll_locked_i  = 1'b0;
        shutdown_i = 1'b1;
        @(negedge clk);
        shutdown_i = 1'b0;
        pulse_start();
        wait_for(1, 1'b1, n);
        pulse_start();
        act = 0;
        n = 1;
        while (phy_rst_o && n < LIMIT) begin
            if (board_rst_o !== 1'b0) act++;
            @(negedge clk);
            n++;
        end
        chk("R9 R5 stab kept", n, T_ST);
        chk("R5 pin idle", act, 0);
        @(negedge clk);
        pll_locked_i = 1'b1;
        repeat (T_G - 1) @(negedge clk);
        pll_locked_i = 1'b0;
        chk("R6 off-grid ignored", done_o, 0);
        pll_locked_i = 1'b1;
        wait_for(4, 1'b1, n);
        chk("R6 next sample", n, 1);
    endtask

    // R7 R8 R10
    task automatic t_timeout();
        int n;
        pulse_start();
        chk("R8 done cleared", done_o, 0);
        pll_locked_i = 1'b0;
        wait_for(3, 1'b0, n);
        wait_for(4, 1'b1, n);
        chk("R7 timeout cycles", n, (PMAX - 1) * T_G + 1);
        chk("R7 err set", lock_to_o, 1);
        pll_locked_i = 1'b1;
        repeat (5) @(negedge clk);
        chk("R8 done held", done_o, 1);
        chk("R8 err held", lock_to_o, 1);
        shutdown_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        shutdown_i = 1'b0;
        start_i = 1'b0;
        check_reset_levels("R10");
        chk("R10 err kept", lock_to_o, 1);
        pulse_start();
        chk("R8 restart clears err", lock_to_o, 0);
        chk("R8 restart pd", phy_pd_o, 0);
        pin_present_i = 1'b1;
        wait_for(2, 1'b1, n);
        repeat (3) @(negedge clk);
        shutdown_i = 1'b1;
        @(negedge clk);
        shutdown_i = 1'b0;
        check_reset_levels("R10 mid-pulse");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full(1'b1);
        shutdown_i = 1'b1;
        @(negedge clk);
        shutdown_i = 1'b0;
        t_full(1'b0);
        t_nopin_grid();
        t_timeout();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule